// File: doc/BRIEF.md
# Data Operand Effective Address Unit

This unit forms the 16-bit address of a data memory operand for a small 8-bit microcontroller core. Each cycle it takes an addressing-mode code, the operation type, the selected address register, the stack pointer and the displacement or absolute field of the instruction. From these it produces the operand address together with one of three exclusive indications: a valid address, an operand that needs no memory address, or an illegal mode.

The address is a combinational function of the inputs and of one stored register. That register holds the address of the last completed memory access. The "reuse last address" mode lets a following byte or word move skip its address field. The register loads at a clock edge when the access-done input is high while a valid address is presented. Reset clears it to zero.

Top module: `data_ea_gen`

## Requirements
- R1: Mode 2 (register indirect) outputs `areg_i` unchanged as the address, with `ea_valid_o`=1.
- R2: Modes 3 and 4 (register relative) output `areg_i` plus `field_i[7:0]` or `field_i[15:0]`. The displacement is sign-extended to 16 bits and the sum wraps modulo 2^16.
- R3: Modes 5, 6 and 7 (stack relative) output `sp_i` plus the sign-extended `field_i[3:0]`, `field_i[7:0]` or `field_i[15:0]`. The sum wraps modulo 2^16.
- R4: Modes 8, 9 and 10 (absolute) output `field_i[15:0]`, `{4'h0, field_i[11:0]}` or `{8'h00, field_i[7:0]}`. Field bits above the used width have no effect.
- R5: Mode 11 (I/O short) outputs 0x3F00 + `field_i[7:0]`.
- R6: Mode 12 (RAM short) outputs `{8'h00, field_i[7:0]}`.
- R7: Mode 13 (reuse) with `op_i`=1 (byte move) or `op_i`=2 (word move) outputs the stored last address with `ea_valid_o`=1. The stored address is zero after reset. It loads the presented address at a clock edge where `access_done_i`=1 and `ea_valid_o`=1, and is left unchanged otherwise.
- R8: Mode 13 with `op_i`=0 or 3, and the reserved modes 14 and 15, set `illegal_o`=1 and `ea_valid_o`=0. The stored address is left unchanged.
- R9: Mode 0 (register direct) and mode 1 (immediate) set `no_mem_o`=1 and `ea_valid_o`=0.
- R10: At most one of `ea_valid_o`, `no_mem_o` and `illegal_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 4 | Addressing-mode code |
| op_i | input | 2 | Operation type: 1 byte move, 2 word move, 0/3 other |
| areg_i | input | 16 | Selected address register |
| sp_i | input | 16 | Stack pointer |
| field_i | input | 16 | Displacement or absolute operand field |
| access_done_i | input | 1 | The memory access at the presented address completes this cycle |
| ea_o | output | 16 | Effective address |
| ea_valid_o | output | 1 | Address is valid |
| no_mem_o | output | 1 | Operand needs no memory address |
| illegal_o | output | 1 | Mode not allowed |

## Verification
The address and the three flags settle in the same cycle as the inputs that produce them. The bench drives inputs on the falling edge and samples the outputs a quarter period later, before the next rising edge. The stored last address takes effect one rising edge after an access-done cycle. The bench model updates its copy at that edge, so the next reuse-mode step is checked against it. Illegal reuse cycles and access-done cycles without a valid address are followed by a legal reuse, which shows at the ports that the register was not changed.

// File: rtl/data_ea_gen.sv
module data_ea_gen #(
  parameter int AW = 16,
  parameter logic [AW-1:0] IO_BASE = 16'h3F00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] areg_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] field_i,
  input  logic          access_done_i,
  output logic [AW-1:0] ea_o,
  output logic          ea_valid_o,
  output logic          no_mem_o,
  output logic          illegal_o
);
  localparam logic [3:0] M_REG = 4'd0, M_IMM = 4'd1, M_IND = 4'd2, M_R8 = 4'd3,
    M_R16 = 4'd4, M_S4 = 4'd5, M_S8 = 4'd6, M_S16 = 4'd7, M_A16 = 4'd8,
    M_A12 = 4'd9, M_A8 = 4'd10, M_IO = 4'd11, M_RAM = 4'd12, M_HANDY = 4'd13;

  logic [AW-1:0] last_q;
  logic [AW-1:0] sx4, sx8, zx8, zx12;
  logic          is_move;

  assign sx4     = {{(AW-4){field_i[3]}}, field_i[3:0]};
  assign sx8     = {{(AW-8){field_i[7]}}, field_i[7:0]};
  assign zx8     = {{(AW-8){1'b0}}, field_i[7:0]};
  assign zx12    = {{(AW-12){1'b0}}, field_i[11:0]};
  assign is_move = (op_i == 2'd1) || (op_i == 2'd2);

  always_comb begin
    ea_o       = '0;
    ea_valid_o = 1'b1;
    no_mem_o   = 1'b0;
    illegal_o  = 1'b0;
    case (mode_i)
      M_REG, M_IMM: begin ea_valid_o = 1'b0; no_mem_o = 1'b1; end
      M_IND:   ea_o = areg_i;
      M_R8:    ea_o = areg_i + sx8;
      M_R16:   ea_o = areg_i + field_i;
      M_S4:    ea_o = sp_i + sx4;
      M_S8:    ea_o = sp_i + sx8;
      M_S16:   ea_o = sp_i + field_i;
      M_A16:   ea_o = field_i;
      M_A12:   ea_o = zx12;
      M_A8:    ea_o = zx8;
      M_IO:    ea_o = IO_BASE + zx8;
      M_RAM:   ea_o = zx8;
      M_HANDY: begin
        ea_o = last_q;
        if (!is_move) begin ea_valid_o = 1'b0; illegal_o = 1'b1; end
      end
      default: begin ea_valid_o = 1'b0; illegal_o = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else if (access_done_i && ea_valid_o) last_q <= ea_o;
  end
endmodule

module data_ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  mode_i,
  input logic [1:0]  op_i,
  input logic [15:0] areg_i,
  input logic [15:0] field_i,
  input logic        access_done_i,
  input logic [15:0] ea_o,
  input logic        ea_valid_o,
  input logic        no_mem_o,
  input logic        illegal_o
);
  logic handy_ok;
  assign handy_ok = (mode_i == 4'd13) && (op_i == 2'd1 || op_i == 2'd2);

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ea_valid_o, no_mem_o, illegal_o}));
  // R9
  no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i < 4'd2) |-> (no_mem_o && !ea_valid_o));
  // R1
  indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd2) |-> (ea_valid_o && ea_o == areg_i));
  // R5
  io_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd11) |-> (ea_o[15:8] == 8'h3F && ea_o[7:0] == field_i[7:0]));
  // R6
  ram_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'd12) |-> (ea_o[15:8] == 8'h00 && ea_valid_o));
  // R8
  illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i >= 4'd13 && !handy_ok) |-> (illegal_o && !ea_valid_o));
  // R7
  reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access_done_i && ea_valid_o) |=> (!handy_ok || ea_o == $past(ea_o)));
endmodule

bind data_ea_gen data_ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .op_i(op_i), .areg_i(areg_i),
  .field_i(field_i), .access_done_i(access_done_i), .ea_o(ea_o),
  .ea_valid_o(ea_valid_o), .no_mem_o(no_mem_o), .illegal_o(illegal_o));

// File: tb/data_ea_gen_tb.sv
module data_ea_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mode_i = '0;
  logic [1:0] op_i = '0;
  logic [15:0] areg_i = '0, sp_i = '0, field_i = '0;
  logic access_done_i = 1'b0;
  logic [15:0] ea_o;
  logic ea_valid_o, no_mem_o, illegal_o;
  int checks = 0, failures = 0;
  logic [15:0] m_last = '0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  data_ea_gen u_dut (.clk(clk), .rst_n(rst_n), .mode_i(mode_i), .op_i(op_i),
    .areg_i(areg_i), .sp_i(sp_i), .field_i(field_i), .access_done_i(access_done_i),
    .ea_o(ea_o), .ea_valid_o(ea_valid_o), .no_mem_o(no_mem_o), .illegal_o(illegal_o));

  function automatic logic [18:0] model(input logic [3:0] m, input logic [1:0] op,
      input logic [15:0] a, input logic [15:0] s, input logic [15:0] f, input logic [15:0] last);
    logic [15:0] sx4 = {{12{f[3]}}, f[3:0]};
    logic [15:0] sx8 = {{8{f[7]}}, f[7:0]};
    case (m)
      4'd0, 4'd1: return {3'b010, 16'h0000};
      4'd2:  return {3'b100, a};
      4'd3:  return {3'b100, a + sx8};
      4'd4:  return {3'b100, a + f};
      4'd5:  return {3'b100, s + sx4};
      4'd6:  return {3'b100, s + sx8};
      4'd7:  return {3'b100, s + f};
      4'd8:  return {3'b100, f};
      4'd9:  return {3'b100, 4'h0, f[11:0]};
      4'd10: return {3'b100, 8'h00, f[7:0]};
      4'd11: return {3'b100, 16'h3F00 + {8'h00, f[7:0]}};
      4'd12: return {3'b100, 8'h00, f[7:0]};
      4'd13: return (op == 2'd1 || op == 2'd2) ? {3'b100, last} : {3'b001, last};
      default: return {3'b001, 16'h0000};
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return "R9";
      4'd2: return "R1";
      4'd3, 4'd4: return "R2";
      4'd5, 4'd6, 4'd7: return "R3";
      4'd8, 4'd9, 4'd10: return "R4";
      4'd11: return "R5";
      4'd12: return "R6";
      4'd13: return "R7/R8";
      default: return "R8";
    endcase
  endfunction

  task automatic step(input logic [3:0] m, input logic [1:0] op, input logic [15:0] a,
      input logic [15:0] s, input logic [15:0] f, input logic ad);
    logic [18:0] exp, act;
    @(negedge clk);
    mode_i = m; op_i = op; areg_i = a; sp_i = s; field_i = f; access_done_i = ad;
    #5;
    exp = model(m, op, a, s, f, m_last);
    act = {ea_valid_o, no_mem_o, illegal_o, (exp[18] ? ea_o : 16'h0000)};
    if (!exp[18]) exp[15:0] = 16'h0000;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s mode=%0d op=%0d act=%h exp=%h", req_of(m), m, op, act, exp);
    end
    checks++;
    if ($countones({ea_valid_o, no_mem_o, illegal_o}) > 1) begin
      failures++;
      $display("FAIL R10 flags act=%b exp=onehot0", {ea_valid_o, no_mem_o, illegal_o});
    end
    @(posedge clk);
    if (ad && exp[18]) m_last = exp[15:0];
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R7 reset value zero
    step(4'd13, 2'd1, 16'h1111, 16'h2222, 16'h3333, 1'b0);
    // R1
    step(4'd2, 2'd0, 16'hBEEF, 16'h0, 16'h0, 1'b0);
    // R2 wrap and negative displacement
    step(4'd3, 2'd0, 16'hFFFF, 16'h0, 16'h0001, 1'b0);
    step(4'd3, 2'd0, 16'h0100, 16'h0, 16'hFF80, 1'b0);
    step(4'd4, 2'd0, 16'h8000, 16'h0, 16'h9000, 1'b0);
    // R3 4-bit negative
    step(4'd5, 2'd0, 16'h0, 16'h0200, 16'hFFFF, 1'b0);
    step(4'd6, 2'd0, 16'h0, 16'h0000, 16'h0080, 1'b0);
    // R4 upper bits ignored
    step(4'd9, 2'd0, 16'h0, 16'h0, 16'hFFFF, 1'b0);
    step(4'd10, 2'd0, 16'h0, 16'h0, 16'hABCD, 1'b0);
    // R5 / R6
    step(4'd11, 2'd0, 16'h0, 16'h0, 16'h12FF, 1'b0);
    step(4'd12, 2'd0, 16'h0, 16'h0, 16'h34A5, 1'b0);
    // R9
    step(4'd1, 2'd2, 16'h0, 16'h0, 16'h0, 1'b1);
    // R7 load then reuse
    step(4'd8, 2'd0, 16'h0, 16'h0, 16'h5A5A, 1'b1);
    step(4'd13, 2'd2, 16'h0, 16'h0, 16'h0, 1'b0);
    // R8 illegal reuse with done, stored value kept
    step(4'd13, 2'd3, 16'h0, 16'h0, 16'h0, 1'b1);
    step(4'd14, 2'd1, 16'h0, 16'h0, 16'hFFFF, 1'b1);
    step(4'd13, 2'd1, 16'h0, 16'h0, 16'h0, 1'b0);
    // R7 no load when done without valid address
    step(4'd0, 2'd1, 16'h0, 16'h0, 16'h0, 1'b1);
    step(4'd13, 2'd1, 16'h0, 16'h0, 16'h0, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] m;
      m = ($urandom % 4 == 0) ? 4'd13 : 4'($urandom % 16);
      step(m, 2'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule